// File: doc/BRIEF.md
# Reset Source Discrimination Sequencer

This block sits inside a processor and owns its side of a shared reset line that any device on the board may pull low. Whenever a reset begins, the sequencer pulls the line low for a fixed stretch and then lets go. It waits a fixed time and then reads the line back. If something else is still holding the line low, the reset came from outside. If the line has already recovered, the processor caused the reset itself.

The sequencer keeps no record of why it pulled the line. The only evidence it uses is the line level after release. An outside reset selects the normal start vector. Once the line is back high, the sequencer also sends a one-cycle strobe that wipes preserved state. A self-caused reset selects an alternate vector and leaves preserved state alone, so that software can investigate the cause.

A sequence can start in two ways: a watchdog or clock-failure request while the block is idle, or a low level on the line seen through the synchronizer. The line enters through a multi-flop synchronizer, and the post-release wait is measured at the synchronizer output.

Top module: `rst_src_seq`

## Requirements
- R1: After the asynchronous power-on reset, the pull-down enable and the clear strobe are 0, the external flag is 1 and the alternate-vector select is 0.
- R2: A watchdog or clock-failure request seen in idle raises the pull-down enable on the next clock edge. The enable then stays high for exactly DRIVE_CYC (4) cycles.
- R3: In idle, a low level on the line starts the same sequence. The pull-down enable rises on the third clock edge after the line goes low: two synchronizer edges plus one decision edge.
- R4: The line is sampled SYNC_STAGES + WAIT_CYC (2 + 2 = 4) cycles after the pull-down enable falls. The flags change on that edge and not before.
- R5: If the sampled line is low (0), the external flag becomes 1 and the alternate-vector select becomes 0.
- R6: If the sampled line is high (1), the external flag becomes 0 and the alternate-vector select becomes 1. No clear strobe is issued for that sequence.
- R7: After an external classification, the clear strobe rises on the third clock edge after the line returns high. It lasts exactly one cycle.
- R8: Fault requests that arrive while a sequence is running are ignored. Once the sequence ends, no second sequence follows.
- R9: The external flag and the alternate-vector select hold their values in idle until the next classification.
- R10: The classification depends on the line level alone. An internal fault whose release finds the line still held low by another device is classified as external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| line_i | input | 1 | Sampled level of the shared reset line (1 = high) |
| fault_wdog_i | input | 1 | Watchdog fault request |
| fault_clk_i | input | 1 | Clock-failure fault request |
| line_pull_o | output | 1 | Enables the pull-down on the shared line |
| src_ext_o | output | 1 | 1 = last reset external, 0 = self-caused |
| vec_alt_o | output | 1 | 1 = alternate vector, 0 = normal vector |
| clr_state_o | output | 1 | One-cycle strobe that clears saved state |

## Verification
A wrong internal state shows up at the ports within a few cycles:
- A miscounted drive phase changes the width of the pull-down pulse, which is visible on the very next edge.
- A wrong wait count moves the flag update off the fourth cycle after release, or makes the block read its own still-synchronizing low level as an outside reset.
- A sequencer that re-arms too early starts a second pull-down pulse after a fault that should have been ignored.
- A lost external-wait state shows up either as a missing clear strobe or as a strobe that lasts more than one cycle.

The directed tests pin each of these to the exact cycle.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_EXTW  = 2'd3
  } rsd_state_e;
endpackage

// File: rtl/rsd_sync.sv
module rsd_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb ff_d = d_i;
    end else begin : g_chain
      always_comb ff_d = {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RESET_VAL}};
    else         ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rsd_timer.sv
module rsd_timer #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == limit_i - CW'(1));

  // R4: while a phase is counting, the count never runs past its limit
  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |-> (cnt_q < limit_i));
endmodule

// File: rtl/rst_src_seq.sv
module rst_src_seq #(
  parameter int DRIVE_CYC   = 4,
  parameter int WAIT_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic fault_wdog_i,
  input  logic fault_clk_i,
  output logic line_pull_o,
  output logic src_ext_o,
  output logic vec_alt_o,
  output logic clr_state_o
);
  import rsd_pkg::*;

  localparam int WAIT_TOT = SYNC_STAGES + WAIT_CYC;
  localparam int CNT_MAX  = (DRIVE_CYC > WAIT_TOT) ? DRIVE_CYC : WAIT_TOT;
  localparam int CW       = $clog2(CNT_MAX) + 1;

  rsd_state_e    st_q, st_d;
  logic          line_s;
  logic          fault_any;
  logic          cnt_clr, cnt_en, cnt_done;
  logic [CW-1:0] cnt_lim;
  logic          cls_en;
  logic          clr_d, clr_q;
  logic          ext_q, ext_d;
  logic          alt_q, alt_d;

  rsd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  assign fault_any = fault_wdog_i | fault_clk_i;
  assign cnt_lim   = (st_q == ST_DRIVE) ? CW'(DRIVE_CYC) : CW'(WAIT_TOT);

  rsd_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .limit_i(cnt_lim),
    .done_o (cnt_done)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    cls_en  = 1'b0;
    clr_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fault_any || !line_s) begin
          st_d    = ST_DRIVE;
          cnt_clr = 1'b1;
        end
      end
      ST_DRIVE: begin
        cnt_en = 1'b1;
        if (cnt_done) begin
          st_d    = ST_WAIT;
          cnt_clr = 1'b1;
        end
      end
      ST_WAIT: begin
        cnt_en = 1'b1;
        if (cnt_done) begin
          cls_en  = 1'b1;
          cnt_clr = 1'b1;
          st_d    = line_s ? ST_IDLE : ST_EXTW;
        end
      end
      ST_EXTW: begin
        if (line_s) begin
          st_d  = ST_IDLE;
          clr_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ext_d = ext_q;
    alt_d = alt_q;
    if (cls_en) begin
      ext_d = ~line_s;
      alt_d = line_s;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      clr_q <= 1'b0;
      ext_q <= 1'b1;
      alt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      clr_q <= clr_d;
      ext_q <= ext_d;
      alt_q <= alt_d;
    end
  end

  assign line_pull_o = (st_q == ST_DRIVE);
  assign src_ext_o   = ext_q;
  assign vec_alt_o   = alt_q;
  assign clr_state_o = clr_q;

  // R2: the pull-down stays on until the drive count completes
  assert_drive_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_pull_o && !cnt_done) |=> line_pull_o);

  // R7: the clear strobe is a single cycle
  assert_clr_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_state_o |=> !clr_state_o);

  // R5: the clear strobe only follows an external classification
  assert_clr_ext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_state_o |-> (src_ext_o && !vec_alt_o));

  // R6: the flag and the vector select always disagree
  assert_flag_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ext_o != vec_alt_o);

  // R9: flags hold while idle
  assert_flag_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |=> ($stable(src_ext_o) && $stable(vec_alt_o)));

  // R8: no new drive phase starts from a running sequence
  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && st_q != ST_DRIVE) |=> !line_pull_o);
endmodule

// File: tb/tb_rst_src_seq.sv
module tb_rst_src_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic ext_low;
  logic wdog, cfail;
  logic pull, ext_f, alt_f, clr_s;
  logic line;
  int   n_chk = 0;
  int   n_fail = 0;

  always #4 clk = ~clk;

  assign line = ~pull & ~ext_low;

  rst_src_seq dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_i      (line),
    .fault_wdog_i(wdog),
    .fault_clk_i (cfail),
    .line_pull_o (pull),
    .src_ext_o   (ext_f),
    .vec_alt_o   (alt_f),
    .clr_state_o (clr_s)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_por();
    rst_n = 1'b0;
    nclk(2);
    chk("R1 pull after reset", pull, 1'b0);
    chk("R1 ext flag after reset", ext_f, 1'b1);
    chk("R1 alt vec after reset", alt_f, 1'b0);
    chk("R1 clr after reset", clr_s, 1'b0);
    rst_n = 1'b1;
    nclk(3);
  endtask

  // self-caused sequence from a watchdog request
  task automatic t_self();
    wdog = 1'b1;
    nclk(1);
    wdog = 1'b0;
    for (int i = 1; i <= 4; i++) chk("R2 pull during drive", pull, 1'b1);
    for (int i = 1; i <= 4; i++) if (i < 4) nclk(1);
    nclk(1);
    chk("R2 pull off after four cycles", pull, 1'b0);
    nclk(3);
    chk("R4 flag unchanged before sample", ext_f, 1'b1);
    nclk(1);
    chk("R6 self ext flag", ext_f, 1'b0);
    chk("R6 self alt vec", alt_f, 1'b1);
    for (int i = 0; i < 6; i++) begin
      chk("R6 no clear strobe", clr_s, 1'b0);
      nclk(1);
    end
  endtask

  task automatic t_drive_width();
    int cnt = 0;
    cfail = 1'b1;
    nclk(1);
    cfail = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (pull) cnt++;
      nclk(1);
    end
    chk("R2 drive width is 4", cnt == 4, 1'b1);
    nclk(4);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 10; i++) nclk(1);
    chk("R9 ext flag held", ext_f, 1'b0);
    chk("R9 alt vec held", alt_f, 1'b1);
  endtask

  task automatic t_ignore();
    int extra = 0;
    cfail = 1'b1;
    nclk(1);
    cfail = 1'b0;
    nclk(1);
    wdog = 1'b1;
    nclk(1);
    wdog = 1'b0;
    nclk(3);
    cfail = 1'b1;
    nclk(1);
    cfail = 1'b0;
    nclk(4);
    for (int i = 0; i < 12; i++) begin
      if (pull) extra++;
      nclk(1);
    end
    chk("R8 no second drive", extra == 0, 1'b1);
  endtask

  task automatic t_external();
    ext_low = 1'b1;
    nclk(2);
    chk("R3 pull not yet", pull, 1'b0);
    nclk(1);
    chk("R3 pull after sync", pull, 1'b1);
    nclk(7);
    chk("R4 flag unchanged before sample", ext_f, 1'b0);
    nclk(1);
    chk("R5 ext flag", ext_f, 1'b1);
    chk("R5 normal vector", alt_f, 1'b0);
    nclk(15);
    chk("R7 no clear while held", clr_s, 1'b0);
    ext_low = 1'b0;
    nclk(2);
    chk("R7 clear not early", clr_s, 1'b0);
    nclk(1);
    chk("R7 clear strobe", clr_s, 1'b1);
    nclk(1);
    chk("R7 clear one cycle", clr_s, 1'b0);
    nclk(4);
  endtask

  task automatic t_fault_held();
    wdog = 1'b1;
    ext_low = 1'b1;
    nclk(1);
    wdog = 1'b0;
    nclk(12);
    chk("R10 fault with line held is external", ext_f, 1'b1);
    chk("R10 normal vector", alt_f, 1'b0);
    ext_low = 1'b0;
    nclk(8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    ext_low = 1'b0;
    wdog = 1'b0;
    cfail = 1'b0;
    rst_n = 1'b0;
    nclk(1);
    do_por();
    t_self();
    t_hold();
    t_drive_width();
    t_ignore();
    t_external();
    t_self();
    t_fault_held();
    t_self();
    do_por();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule